// File: doc/BRIEF.md
# Triplicated Configuration Register Slave on a Two-Wire Bus

This block holds the configuration registers of one readout chip among many on a shared two-wire serial bus (SCL/SDA). Each chip answers to a 7-bit address taken from strapped geographical pins. Every chip also accepts writes sent to a common broadcast address, so a single frame loads a default setting into all chips on the line at once. SDA is open-drain. The block releases the line or pulls it low through an output enable, and the resolved line level comes back on `sda_i`.

A write frame is START, then the address byte with W, then a register byte, then a data byte, then STOP. The slave acknowledges each byte. A read takes two steps. An address-only write sets the register pointer. A read frame then returns the byte at that pointer, MSB first. The pointer frame may end in a STOP or in a repeated START.

Every register bit is stored in three copies. Outputs and read-back always show the bitwise 2-of-3 majority. When the copies disagree, a background scrub rewrites all three with the voted value. The voted image drives a parallel bus for the chip's analog and digital settings, and it can be read back at any time. Both bus lines pass through two-flop synchronisers and are sampled on the system clock.

Top module: `cfg_i2c_slave`

## Requirements
- R1: An address byte whose upper 7 bits equal `geo_addr_i` is acknowledged: SDA is pulled low during the 9th clock. SDA is only ever asserted while the synchronised SCL is low.
- R2: A write frame to the own address stores the data byte at the register index given by the register byte. The new value appears on `cfg_o[8*index +: 8]`.
- R3: After an address-only write sets the pointer, a read frame returns the register at the pointer, MSB first, on eight consecutive clocks.
- R4: Broadcast address 7'h00 with R/W bit 0 is acknowledged, and the write updates the register. Broadcast address with R/W bit 1 is not acknowledged, and SDA is never driven for that frame.
- R5: A write to a register index of `NUM_REGS` or above is acknowledged but changes no register. A read of such an index returns 8'h00.
- R6: Each register bit is held in three copies. `cfg_o` and read data carry the bitwise majority, so corruption of any single copy is invisible at the outputs.
- R7: Whenever the copies disagree, all three are rewritten with the voted value on the next clock. A later corruption of a different copy is therefore still masked.
- R8: A frame addressed to any other 7-bit address gets no acknowledge, never drives SDA, and leaves all registers unchanged.
- R9: A START seen at any point, including mid-byte or after the pointer frame (repeated START), restarts address reception. A STOP returns the slave to idle.
- R10: After reset all registers read 8'h00 and SDA is released.
- R11: After the data byte of a read frame, the slave releases SDA for the master's acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Resolved bus data line level |
| geo_addr_i | input | 7 | Strapped geographical slave address |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_o | output | NUM_REGS*8 | Voted register image, register k in bits [8k+7:8k] |

## Verification
The bench targets the broadcast address in both directions. A slave that acknowledged broadcast reads would fight other chips on SDA. A slave that rejected broadcast writes would leave chips unconfigured. Out-of-range register indices must not alias onto low registers, which a truncated index compare would do. Repeated and mid-byte STARTs must resynchronise the byte counter, or the next frame decodes shifted bits.

The bench upsets one copy of a register and checks that the outputs do not move. It then upsets a second, different copy in the same way. Only a working scrub keeps that second upset masked; without it two copies agree on the wrong value.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int REG_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } i2c_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  // data edges with clock held high
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/tmr_copy.sv
module tmr_copy #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bits_q <= '0;
    else if (we_i) bits_q <= d_i;
  end

  assign q_o = bits_q;
endmodule

// File: rtl/tmr_reg_bank.sv
module tmr_reg_bank #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [7:0]                wr_addr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  input  logic [7:0]                rd_addr_i,
  output logic [REG_W-1:0]          rd_data_o,
  output logic [NUM_REGS*REG_W-1:0] voted_o
);
  localparam int IMG_W = NUM_REGS * REG_W;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [IMG_W-1:0] copy_q [3];
  logic [IMG_W-1:0] next_img;
  logic [REG_W-1:0] reg_a [NUM_REGS];
  logic             wr_hit, mismatch, copy_we;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_idx   = wr_addr_i[IDX_W-1:0];
  assign rd_idx   = rd_addr_i[IDX_W-1:0];
  assign wr_hit   = wr_en_i && (int'(wr_addr_i) < NUM_REGS);
  assign voted_o  = (copy_q[0] & copy_q[1]) | (copy_q[1] & copy_q[2]) | (copy_q[0] & copy_q[2]);
  assign mismatch = (copy_q[0] != copy_q[1]) || (copy_q[1] != copy_q[2]);
  assign copy_we  = wr_hit || mismatch;

  // host write merged into the voted image; also serves as scrub data
  always_comb begin
    next_img = voted_o;
    if (wr_hit) next_img[wr_idx*REG_W +: REG_W] = wr_data_i;
  end

  for (genvar c = 0; c < 3; c++) begin : g_copy
    tmr_copy #(.W(IMG_W)) u_copy (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (copy_we),
      .d_i   (next_img),
      .q_o   (copy_q[c])
    );
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_rd
    assign reg_a[r] = voted_o[r*REG_W +: REG_W];
  end

  assign rd_data_o = (int'(rd_addr_i) < NUM_REGS) ? reg_a[rd_idx] : '0;

  // R6
  vote_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_q[0] == copy_q[1]) |-> (voted_o == copy_q[0]));

  // R7
  scrub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch && !wr_hit) |=> !mismatch);
endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] BCAST_ADDR = 7'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [6:0] geo_addr_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] reg_ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  i2c_st_e    st_q;
  logic [7:0] sh_q, tx_q;
  logic [3:0] cnt_q;
  logic       rd_q, bc_q;
  logic       own_hit, bc_hit, rx_state;

  assign own_hit  = (sh_q[7:1] == geo_addr_i);
  assign bc_hit   = (sh_q[7:1] == BCAST_ADDR) && !sh_q[0];
  assign rx_state = (st_q == ST_ADDR) || (st_q == ST_REG) || (st_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      tx_q      <= '0;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      bc_q      <= 1'b0;
      reg_ptr_o <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      sda_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        if (rx_state && scl_rise_i) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end
        if (scl_fall_i) begin
          case (st_q)
            ST_ADDR: if (cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (own_hit || bc_hit) begin
                sda_oe_o <= 1'b1;
                rd_q     <= sh_q[0];
                bc_q     <= !own_hit;
                st_q     <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_WAIT;
              end
            end
            ST_REG: if (cnt_q == 4'd8) begin
              cnt_q     <= '0;
              reg_ptr_o <= sh_q;
              sda_oe_o  <= 1'b1;
              st_q      <= ST_REG_ACK;
            end
            ST_DATA: if (cnt_q == 4'd8) begin
              cnt_q     <= '0;
              wr_en_o   <= 1'b1;
              wr_data_o <= sh_q;
              sda_oe_o  <= 1'b1;
              st_q      <= ST_DATA_ACK;
            end
            ST_ADDR_ACK: begin
              if (rd_q) begin
                sda_oe_o <= ~rd_data_i[7];
                tx_q     <= {rd_data_i[6:0], 1'b0};
                cnt_q    <= 4'd1;
                st_q     <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_REG;
              end
            end
            ST_REG_ACK: begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_DATA;
            end
            ST_DATA_ACK: begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_WAIT;
            end
            ST_TX: begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_TX_ACK;
              end else begin
                sda_oe_o <= ~tx_q[7];
                tx_q     <= {tx_q[6:0], 1'b0};
                cnt_q    <= cnt_q + 4'd1;
              end
            end
            default: ;
          endcase
        end
        if (st_q == ST_TX_ACK && scl_rise_i) st_q <= ST_WAIT;
      end
    end
  end

  // R4
  bcast_no_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX) |-> !bc_q);

  // R10
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS   = 16,
  parameter logic [6:0] BCAST_ADDR = 7'h00
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic [6:0]                geo_addr_i,
  output logic                      sda_oe_o,
  output logic [NUM_REGS*REG_W-1:0] cfg_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] reg_ptr, wr_data, rd_data;
  logic       wr_en;

  i2c_line_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_cfg_fsm #(.BCAST_ADDR(BCAST_ADDR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .geo_addr_i(geo_addr_i),
    .rd_data_i (rd_data),
    .reg_ptr_o (reg_ptr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  tmr_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(reg_ptr),
    .wr_data_i(wr_data),
    .rd_addr_i(reg_ptr),
    .rd_data_o(rd_data),
    .voted_o  (cfg_o)
  );

  // R1
  oe_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  // R2
  wr_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && int'(reg_ptr) < NUM_REGS) |=> (cfg_o[$past(reg_ptr)*REG_W +: REG_W] == $past(wr_data)));

  // R5
  oob_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && int'(reg_ptr) >= NUM_REGS) |=> $stable(cfg_o));
endmodule

// File: tb/sim_cfg_i2c_slave.sv
`timescale 1ns/1ps
module sim_cfg_i2c_slave;
  localparam int NR = 16;
  localparam int Q  = 10;
  localparam logic [6:0] BC = 7'h00;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            scl_m, sda_m;
  logic [6:0]      geo;
  logic            sda_oe;
  logic [NR*8-1:0] cfg;
  wire             sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int oe_cnt = 0;
  logic [7:0] model [NR];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;
  always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

  cfg_i2c_slave #(.NUM_REGS(NR), .BCAST_ADDR(BC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .geo_addr_i(geo), .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] img();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; hq(); endtask
  task automatic i2c_stop(); sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq(); endtask
  task automatic send_bit(input logic b); sda_m = b; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq(); endtask
  task automatic recv_bit(output logic b); sda_m = 1; hq(); scl_m = 1; hq(); b = sda_line; hq(); scl_m = 0; hq(); endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic write_reg(input logic [6:0] dev, input logic [7:0] r, input logic [7:0] d,
                           input logic exp_ack, input string tag);
    logic a0, a1, a2;
    int oe0;
    oe0 = oe_cnt;
    i2c_start();
    send_byte({dev, 1'b0}, a0);
    send_byte(r, a1);
    send_byte(d, a2);
    i2c_stop();
    check(a0 == exp_ack && a1 == exp_ack && a2 == exp_ack, tag, {a0, a1, a2}, {3{exp_ack}});
    if (!exp_ack) check(oe_cnt == oe0, {tag, " no drive"}, oe_cnt, oe0);
    if (exp_ack && int'(r) < NR) model[r] = d;
    repeat (4) @(negedge clk);
    check(cfg == img(), {tag, " image"}, cfg, img());
  endtask

  task automatic read_reg(input logic [6:0] dev, input logic [7:0] r, input bit rep, input string tag);
    logic a;
    logic nb;
    logic [7:0] d;
    i2c_start();
    send_byte({dev, 1'b0}, a);
    check(a, {tag, " ptr addr ack"}, a, 1);
    send_byte(r, a);
    check(a, {tag, " ptr reg ack"}, a, 1);
    if (!rep) i2c_stop();
    i2c_start();
    send_byte({dev, 1'b1}, a);
    check(a, {tag, " read addr ack"}, a, 1);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    // master NACK: slave must have let go of the line
    sda_m = 1; hq(); scl_m = 1; hq(); nb = sda_line; hq(); scl_m = 0; hq();
    check(nb == 1'b1, "R11 released for master ack", nb, 1);
    i2c_stop();
    exp_q.push_back(int'(r) < NR ? model[r] : 8'h00);
    act_q.push_back(d);
    tag_q.push_back(tag);
  endtask

  // monitor: pops read results and compares against expected queue
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(a == e, t, a, e);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NR*8-1:0] flip, base;
    logic a;
    int oe0;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    geo = 7'h2A; scl_m = 1; sda_m = 1; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R10
    check(cfg == '0, "R10 reset image", cfg, 0);
    check(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);

    // R1 R2
    write_reg(7'h2A, 8'h03, 8'hA5, 1'b1, "R1 R2 own write r3");
    write_reg(7'h2A, 8'h00, 8'h3C, 1'b1, "R2 own write r0");
    write_reg(7'h2A, 8'h0F, 8'h81, 1'b1, "R2 own write r15");

    // R3
    read_reg(7'h2A, 8'h03, 1'b0, "R3 read r3");
    read_reg(7'h2A, 8'h00, 1'b0, "R3 read r0");
    read_reg(7'h2A, 8'h0F, 1'b0, "R3 read r15");

    // R9 repeated start
    read_reg(7'h2A, 8'h0F, 1'b1, "R9 repeated start read r15");

    // R9 start mid-byte aborts the partial byte
    i2c_start();
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    write_reg(7'h2A, 8'h07, 8'h5E, 1'b1, "R9 mid-byte restart write r7");

    // R4 broadcast write then broadcast read
    write_reg(BC, 8'h05, 8'h77, 1'b1, "R4 broadcast write r5");
    oe0 = oe_cnt;
    i2c_start();
    send_byte({BC, 1'b1}, a);
    i2c_stop();
    check(a == 1'b0, "R4 broadcast read nack", a, 0);
    check(oe_cnt == oe0, "R4 broadcast read no drive", oe_cnt, oe0);

    // R8 foreign address
    write_reg(7'h2B, 8'h03, 8'h00, 1'b0, "R8 foreign write");

    // R1 pins follow geo change
    geo = 7'h11;
    repeat (4) @(negedge clk);
    write_reg(7'h11, 8'h01, 8'hC3, 1'b1, "R1 new geo write");
    write_reg(7'h2A, 8'h01, 8'h00, 1'b0, "R1 old geo ignored");

    // R5 out of range
    write_reg(7'h11, 8'h20, 8'hFF, 1'b1, "R5 oob write");
    read_reg(7'h11, 8'h20, 1'b0, "R5 oob read zero");

    // R6 single copy upset masked
    repeat (10) @(negedge clk);
    base = img();
    flip = '0;
    flip[3*8 +: 8] = 8'hFF;
    force u0.u_bank.g_copy[1].u_copy.bits_q = base ^ flip;
    #1;
    check(cfg == base, "R6 upset copy1 masked", cfg, base);
    release u0.u_bank.g_copy[1].u_copy.bits_q;
    repeat (5) @(negedge clk);
    // R7 second copy upset after scrub
    force u0.u_bank.g_copy[2].u_copy.bits_q = base ^ flip;
    #1;
    check(cfg[3*8 +: 8] == 8'hA5, "R7 scrub then copy2 upset masked", cfg[3*8 +: 8], 8'hA5);
    release u0.u_bank.g_copy[2].u_copy.bits_q;
    repeat (5) @(negedge clk);
    check(cfg == base, "R7 image after scrub", cfg, base);
    read_reg(7'h11, 8'h03, 1'b0, "R6 read after upsets");

    repeat (20) @(negedge clk);
    check(act_q.size() == 0 && exp_q.size() == 0, "R3 scoreboard drained", act_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule